// File: doc/BRIEF.md
# Power-Good Strap Capture Latch

This block fixes a clock generator's startup configuration from a set of strap inputs. Three frequency-select straps and one shared-pin mode strap are read once, on the first valid low sample of an active-low power-good input. From then on the chosen setting is held, and later activity on power-good or on the straps cannot change it. Only a full device reset clears the hold.

Power-good passes through a synchroniser. A low counts as valid only once the synchronised signal has been low on a set number of consecutive samples, so a short glitch cannot trigger the capture.

The outputs are:
- a decoded host-clock frequency code;
- a flag for codes that are not defined;
- a test-mode flag;
- a flag that selects whether two shared pins act as clock-request inputs or as extra clock outputs;
- a ready flag.

When the select-C strap reads high at the capture, the block enters test mode. In test mode the frequency and shared-pin selections keep following the pins, with one cycle of delay.

Top module: `pgs_strap_latch`

## Requirements
- R1: While in reset, and after reset until the capture, the outputs are fixed: `ready_o`=0, `host_freq_o`=00, `bad_code_o`=0, `test_mode_o`=0 and `clk_pins_o`=0.
- R2: A low on `pg_ni` that the first synchroniser stage sees on only one rising edge does not cause a capture.
- R3: The capture happens on the fourth rising edge, counting the first edge that samples `pg_ni` low. That low must last at least two cycles. On the capture edge `ready_o` rises and the straps are sampled.
- R4: The code `host_freq_o` is decoded from the straps taken as {c,b,a}. The result is 00 (100 MHz) for 101, 01 (133 MHz) for 001, 10 (166 MHz) for 011 and 11 (200 MHz) for 010.
- R5: Any other {c,b,a} gives `host_freq_o`=00 and `bad_code_o`=1. Every listed code gives `bad_code_o`=0.
- R6: Outside test mode, once captured, later changes on `pg_ni`, `sel_a_i`, `sel_b_i`, `sel_c_i` and `pin_mode_i` leave every output unchanged.
- R7: `test_mode_o` equals `sel_c_i` at the capture and then holds. In test mode, `host_freq_o`, `bad_code_o` and `clk_pins_o` follow the straps one cycle after each change, and `ready_o` stays 1 even if `pg_ni` goes high.
- R8: `clk_pins_o` equals `pin_mode_i` at the capture. A value of 0 means the two shared pins are request inputs, and 1 means they are extra clock outputs.
- R9: Only `rst_ni` clears the capture. A new capture after reset again needs the full qualified power-good sequence of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pg_ni | input | 1 | Active-low power-good, asynchronous |
| sel_a_i | input | 1 | Frequency-select strap A |
| sel_b_i | input | 1 | Frequency-select strap B |
| sel_c_i | input | 1 | Frequency-select strap C; high at capture selects test mode |
| pin_mode_i | input | 1 | Shared-pin function strap |
| host_freq_o | output | 2 | Host frequency code: 00=100, 01=133, 10=166, 11=200 MHz |
| bad_code_o | output | 1 | Captured select code is not defined |
| test_mode_o | output | 1 | Test mode is active |
| clk_pins_o | output | 1 | Shared pins act as clock outputs (1) or request inputs (0) |
| ready_o | output | 1 | Straps have been captured |

## Verification
Two stages of synchronisation and two qualifying samples mean the capture lands on the fourth rising edge after `pg_ni` is driven low. The bench therefore queues a "not yet ready" item for the third edge and the captured values for the fourth. In test mode a strap change shows one edge later, so each expected item is due one cycle after the change. For the hold and glitch cases, the items are due several cycles after the stimulus, so that a late capture or a late leak would be seen. The scoreboard compares every item against the ports at the falling edge of its due cycle.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [1:0] {
    HOST_100 = 2'd0,
    HOST_133 = 2'd1,
    HOST_166 = 2'd2,
    HOST_200 = 2'd3
  } host_freq_e;

  typedef struct packed {
    logic sel_c;
    logic sel_b;
    logic sel_a;
    logic pin_mode;
  } strap_t;
endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[i] <= 1'b1;  // idle = not good
      else if (i == 0) stage_q[i] <= d_i;
      else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pgs_low_qual.sv
module pgs_low_qual #(
  parameter int LOW_SAMPLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,
  output logic valid_o
);
  localparam int CW = $clog2(LOW_SAMPLES + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(LOW_SAMPLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(LOW_SAMPLES - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             run_q <= '0;
    else if (!low_i)         run_q <= '0;
    else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
  end

  assign valid_o = low_i && (run_q >= CNT_LAST);

  if (LOW_SAMPLES > 1) begin : g_ast
    AST_VALID_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> $past(low_i));  // R2
  end
endmodule

// File: rtl/pgs_capture.sv
module pgs_capture
  import pgs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   valid_i,
  input  strap_t strap_i,
  output logic   locked_o,
  output logic   test_o,
  output strap_t strap_o
);
  logic   locked_q;
  logic   test_q;
  strap_t cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      test_q   <= 1'b0;
      cap_q    <= '0;
    end else if (!locked_q) begin
      if (valid_i) begin
        locked_q <= 1'b1;
        test_q   <= strap_i.sel_c;
        cap_q    <= strap_i;
      end
    end else if (test_q) begin
      cap_q <= strap_i;  // test mode stays transparent
    end
  end

  assign locked_o = locked_q;
  assign test_o   = test_q;
  assign strap_o  = cap_q;

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);  // R9
  AST_LOCK_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(valid_i));  // R3
  AST_HOLD_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && !test_q) |=> $stable(cap_q));  // R6
  AST_TEST_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> $stable(test_q));  // R7
  AST_TEST_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && test_q) |=> (cap_q == $past(strap_i)));  // R7
endmodule

// File: rtl/pgs_decode.sv
module pgs_decode
  import pgs_pkg::*;
(
  input  logic       locked_i,
  input  strap_t     strap_i,
  output host_freq_e freq_o,
  output logic       bad_o,
  output logic       clk_pins_o
);
  always_comb begin
    freq_o     = HOST_100;
    bad_o      = 1'b0;
    clk_pins_o = 1'b0;
    if (locked_i) begin
      clk_pins_o = strap_i.pin_mode;
      unique case ({strap_i.sel_c, strap_i.sel_b, strap_i.sel_a})
        3'b101:  freq_o = HOST_100;
        3'b001:  freq_o = HOST_133;
        3'b011:  freq_o = HOST_166;
        3'b010:  freq_o = HOST_200;
        default: begin
          freq_o = HOST_100;
          bad_o  = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pgs_strap_latch.sv
module pgs_strap_latch
  import pgs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOW_SAMPLES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pg_ni,
  input  logic       sel_a_i,
  input  logic       sel_b_i,
  input  logic       sel_c_i,
  input  logic       pin_mode_i,
  output logic [1:0] host_freq_o,
  output logic       bad_code_o,
  output logic       test_mode_o,
  output logic       clk_pins_o,
  output logic       ready_o
);
  logic       pg_sync_n;
  logic       pg_valid;
  logic       locked;
  logic       test_mode;
  strap_t     strap_in;
  strap_t     strap_cap;
  host_freq_e freq;

  assign strap_in = '{sel_c: sel_c_i, sel_b: sel_b_i, sel_a: sel_a_i, pin_mode: pin_mode_i};

  pgs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pg_ni),
    .q_o   (pg_sync_n)
  );

  pgs_low_qual #(.LOW_SAMPLES(LOW_SAMPLES)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .low_i  (!pg_sync_n),
    .valid_o(pg_valid)
  );

  pgs_capture u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (pg_valid),
    .strap_i (strap_in),
    .locked_o(locked),
    .test_o  (test_mode),
    .strap_o (strap_cap)
  );

  pgs_decode u_dec (
    .locked_i  (locked),
    .strap_i   (strap_cap),
    .freq_o    (freq),
    .bad_o     (bad_code_o),
    .clk_pins_o(clk_pins_o)
  );

  assign host_freq_o = freq;
  assign test_mode_o = test_mode;
  assign ready_o     = locked;

  AST_IDLE_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (host_freq_o == 2'b00 && !bad_code_o && !test_mode_o && !clk_pins_o));  // R1
  AST_BAD_IS_100: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_code_o |-> (host_freq_o == 2'b00));  // R5
  AST_READY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);  // R7
endmodule

// File: tb/pgs_strap_latch_tb.sv
module pgs_strap_latch_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pg_ni = 1'b1;
  logic       sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0, pin_mode = 1'b0;
  logic [1:0] host_freq;
  logic       bad_code, test_mode, clk_pins, ready;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    logic       ready;
    logic [1:0] freq;
    logic       bad;
    logic       test;
    logic       clkp;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pgs_strap_latch u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .pg_ni      (pg_ni),
    .sel_a_i    (sel_a),
    .sel_b_i    (sel_b),
    .sel_c_i    (sel_c),
    .pin_mode_i (pin_mode),
    .host_freq_o(host_freq),
    .bad_code_o (bad_code),
    .test_mode_o(test_mode),
    .clk_pins_o (clk_pins),
    .ready_o    (ready)
  );

  // Reference decode from the requirements (R4, R5)
  function automatic logic [1:0] ref_freq(input logic c, input logic b, input logic a);
    case ({c, b, a})
      3'b001:  return 2'b01;
      3'b011:  return 2'b10;
      3'b010:  return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic ref_bad(input logic c, input logic b, input logic a);
    return !({c, b, a} inside {3'b101, 3'b001, 3'b011, 3'b010});
  endfunction

  task automatic push(input int dly, input logic r, input logic [1:0] f, input logic bd,
                      input logic t, input logic cp, input string tag);
    exp_t e;
    e.due = cyc + dly; e.ready = r; e.freq = f; e.bad = bd; e.test = t; e.clkp = cp; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic push_idle(input int dly, input string tag);
    push(dly, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_straps(input logic c, input logic b, input logic a, input logic pm);
    sel_c = c; sel_b = b; sel_a = a; pin_mode = pm;
  endtask

  // Monitor: pop items whose due cycle has come
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (e.due != cyc || ready !== e.ready || host_freq !== e.freq || bad_code !== e.bad ||
          test_mode !== e.test || clk_pins !== e.clkp) begin
        failures++;
        $display("FAIL %s cyc=%0d: got rdy=%b f=%b bad=%b tst=%b clk=%b exp rdy=%b f=%b bad=%b tst=%b clk=%b (due %0d)",
                 e.tag, cyc, ready, host_freq, bad_code, test_mode, clk_pins,
                 e.ready, e.freq, e.bad, e.test, e.clkp, e.due);
      end
    end
  end

  // Reset with pg held low and given straps; capture expected on 4th edge (R3, R9)
  task automatic reset_and_lock(input logic c, input logic b, input logic a, input logic pm,
                                input string tag);
    rst_ni = 1'b0;
    set_straps(c, b, a, pm);
    pg_ni = 1'b0;
    push_idle(1, "R1 in reset");
    tick(2);
    rst_ni = 1'b1;
    push_idle(3, "R9 no capture before qualified sequence");
    push(4, 1'b1, ref_freq(c, b, a), ref_bad(c, b, a), c, pm, tag);
    tick(5);
  endtask

  initial begin
    tick(3);
    push_idle(1, "R1 reset state");
    tick(1);
    rst_ni = 1'b1;
    push_idle(3, "R1 idle after reset");
    tick(4);

    // R2: one-cycle glitch
    set_straps(0, 1, 0, 1);
    pg_ni = 1'b0;
    tick(1);
    pg_ni = 1'b1;
    push_idle(6, "R2 glitch ignored");
    tick(8);

    // R3, R4, R8: two-cycle low pulse, code 001 -> 133, clock pins
    set_straps(0, 0, 1, 1);
    pg_ni = 1'b0;
    push_idle(3, "R3 not ready on third edge");
    push(4, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, "R3 R4 R8 capture 133 pins=clk");
    tick(2);
    pg_ni = 1'b1;
    tick(4);

    // R6: later changes ignored
    set_straps(0, 1, 0, 0);
    pg_ni = 1'b0;
    push(3, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, "R6 hold during pg low");
    tick(6);
    pg_ni = 1'b1;
    set_straps(1, 1, 1, 0);
    push(4, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, "R6 hold after pg high");
    tick(6);

    reset_and_lock(0, 1, 0, 0, "R4 R8 R9 capture 200 pins=req");
    reset_and_lock(0, 1, 1, 1, "R4 capture 166");
    reset_and_lock(0, 0, 0, 0, "R5 undefined code");
    set_straps(0, 0, 1, 1);
    push(3, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, "R6 R5 bad code held");
    tick(4);

    // R7: test mode
    reset_and_lock(1, 0, 1, 1, "R7 R4 test mode 100");
    set_straps(0, 0, 1, 0);
    push(1, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, "R7 tracks to 133");
    tick(2);
    set_straps(1, 1, 1, 0);
    push(1, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, "R7 R5 tracks to bad");
    tick(2);
    set_straps(0, 1, 0, 1);
    pg_ni = 1'b1;
    push(1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1, "R7 tracks to 200");
    push(5, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1, "R7 ready kept after pg high");
    tick(7);

    while (sb_q.size() > 0) tick(1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule